// File: doc/BRIEF.md
# Indirect Control and Status Register Bank

This block is the host-facing register bank of a network controller. The host reaches many internal registers through two locations. An index port holds the number of the register to be accessed. A data port then reads or writes the register that the index points at. Both ports sit on one simple synchronous bus. A write takes effect at the clock edge, and read data is combinational from the registered state.

Register 0 is the master control register. Its three command bits put the controller into its stopped, started or initialising state, and a stop written together with the other commands takes priority. The same register carries interrupt-style event flags. Internal units raise these flags with single-cycle pulses, and software clears them by writing one. A summary error bit shows whether any error flag is up. Registers 1 to NCFG hold configuration. They can only be written while the controller is stopped, so a running controller never sees its configuration change under it.

Top module: `ctl_regfile`

## Requirements
- R1: After reset, register 0 reads 0x0004: stop (bit 2) is 1, start (bit 1), init (bit 0) and all flags are 0. The index reads 0 and every configuration register reads 0.
- R2: A write to the index port (bus_port=0) stores the low IW bits of the data, and a read of the index port returns that value.
- R3: A write to register 0 with bit 2 set leaves stop=1, start=0 and init=0, whatever bits 1 and 0 carry.
- R4: Without bit 2, writing 1 to bit 1 sets start and writing 1 to bit 0 sets init, and either one clears stop. Writing 0 to a command bit leaves it unchanged.
- R5: Event flags sit at bits 4 (memory error), 5 (babble), 6 (missed frame) and 7 (transmit started), and are set by ev_set[0..3]. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R6: If a set pulse and a write-one-clear hit the same flag in the same cycle, the flag ends up set.
- R7: A write to register 0 with bit 2 set clears all event flags, except where a set pulse arrives in the same cycle.
- R8: Bit 3 of register 0 reads as the OR of bits 4, 5 and 6. It does not depend on bit 7. Bits above 7 read 0.
- R9: A write to configuration registers 1..NCFG updates them only while stop is 1. While running, the write is ignored and the register reads back its old value.
- R10: An index above NCFG reads 0 on the data port, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_port | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the selected port |
| ev_set | input | 4 | Set pulses for event flags (bits 4..7 of register 0) |
| stop_o | output | 1 | Stopped state |
| start_o | output | 1 | Started state |
| init_o | output | 1 | Initialisation requested |
| cfg_o | output | NCFG*DW | Configuration registers, register 1 in the low word |

## Verification
Because every bit of state is reachable through the read path, an internal error shows up on bus_rdata on the first read after the edge that caused it. A wrong command priority is also visible at once on stop_o, start_o and init_o, one cycle after the write. A flag that failed to latch or failed to clear shows in the master read and in the summary error bit. A gating fault shows as a configuration word changing on cfg_o while start_o is high.

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int DW   = 16,
  parameter int IW   = 6,
  parameter int NCFG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_port,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [3:0]        ev_set,
  output logic              stop_o,
  output logic              start_o,
  output logic              init_o,
  output logic [NCFG*DW-1:0] cfg_o
);
  logic [IW-1:0] idx_q;
  logic [3:0]    flag_q, flag_d;
  logic          stop_q, start_q, init_q;
  logic [DW-1:0] cfg_q [NCFG];
  logic          wr_idx, wr_dat, wr_mst, halt_req;
  logic [DW-1:0] mst_val, cfg_val;

  assign wr_idx   = bus_wr & ~bus_port;
  assign wr_dat   = bus_wr & bus_port;
  assign wr_mst   = wr_dat & (idx_q == '0);
  assign halt_req = wr_mst & bus_wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (wr_idx) idx_q <= bus_wdata[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q  <= 1'b1;
      start_q <= 1'b0;
      init_q  <= 1'b0;
    end else if (halt_req) begin
      stop_q  <= 1'b1;
      start_q <= 1'b0;
      init_q  <= 1'b0;
    end else if (wr_mst) begin
      if (bus_wdata[1]) begin
        start_q <= 1'b1;
        stop_q  <= 1'b0;
      end
      if (bus_wdata[0]) begin
        init_q <= 1'b1;
        stop_q <= 1'b0;
      end
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (halt_req) flag_d = '0;
    else if (wr_mst) flag_d = flag_q & ~bus_wdata[7:4];
    flag_d = flag_d | ev_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else flag_q <= flag_d;
  end

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[i] <= '0;
      else if (wr_dat && stop_q && idx_q == IW'(i + 1)) cfg_q[i] <= bus_wdata;
    end
    assign cfg_o[i*DW +: DW] = cfg_q[i];
  end

  assign mst_val = {{(DW-8){1'b0}}, flag_q, |flag_q[2:0], stop_q, start_q, init_q};

  always_comb begin
    cfg_val = '0;
    for (int i = 0; i < NCFG; i++)
      if (idx_q == IW'(i + 1)) cfg_val = cfg_q[i];
  end

  assign bus_rdata = !bus_port ? DW'(idx_q) : (idx_q == '0) ? mst_val : cfg_val;
  assign stop_o  = stop_q;
  assign start_o = start_q;
  assign init_o  = init_q;
endmodule

module ctl_regfile_chk #(
  parameter int DW   = 16,
  parameter int IW   = 6,
  parameter int NCFG = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_port,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic [3:0]         ev_set,
  input logic               stop_o,
  input logic               start_o,
  input logic               init_o,
  input logic [NCFG*DW-1:0] cfg_o,
  input logic [IW-1:0]      idx_q,
  input logic [3:0]         flag_q
);
  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_port) |=> idx_q == $past(bus_wdata[IW-1:0]));

  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_port && idx_q == '0 && bus_wdata[2]) |=> (stop_o && !start_o && !init_o));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((flag_q & $past(ev_set)) == $past(ev_set)));

  p_halt_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_port && idx_q == '0 && bus_wdata[2] && ev_set == '0) |=> flag_q == '0);

  p_err_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_port && idx_q == '0) |-> (bus_rdata[3] == (|bus_rdata[6:4])));

  p_cfg_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_port && !stop_o) |=> $stable(cfg_o));
endmodule

bind ctl_regfile ctl_regfile_chk #(.DW(DW), .IW(IW), .NCFG(NCFG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_set(ev_set),
  .stop_o(stop_o), .start_o(start_o), .init_o(init_o), .cfg_o(cfg_o),
  .idx_q(idx_q), .flag_q(flag_q)
);

// File: tb/ctl_regfile_tb.sv
module ctl_regfile_tb;
  localparam int DW = 16, IW = 6, NCFG = 4;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OP = 2'd2;

  function automatic logic [22:0] mk(logic [1:0] op, logic p, logic [3:0] s, logic [15:0] d);
    return {op, p, s, d};
  endfunction

  localparam int NV = 36;
  localparam logic [22:0] VEC [NV] = '{
    mk(OW,0,4'h0,16'h0000), mk(OR,1,4'h0,16'h0004),  // R1
    mk(OR,0,4'h0,16'h0000),                          // R2
    mk(OW,0,4'h0,16'h0001), mk(OW,1,4'h0,16'h1234), mk(OR,1,4'h0,16'h1234), // R9 stopped
    mk(OW,0,4'h0,16'h0005), mk(OW,1,4'h0,16'hFFFF), mk(OR,1,4'h0,16'h0000), // R10
    mk(OR,0,4'h0,16'h0005),                          // R2
    mk(OW,0,4'h0,16'h0000), mk(OW,1,4'h0,16'h0002), mk(OR,1,4'h0,16'h0002), // R4 start
    mk(OW,0,4'h0,16'h0001), mk(OW,1,4'h0,16'hBEEF), mk(OR,1,4'h0,16'h1234), // R9 running
    mk(OW,0,4'h0,16'h0000), mk(OP,1,4'h1,16'h0000), mk(OR,1,4'h0,16'h001A), // R5 R8
    mk(OP,1,4'h8,16'h0000), mk(OR,1,4'h0,16'h009A),  // R8 bit7 not error
    mk(OW,1,4'h0,16'h0080), mk(OR,1,4'h0,16'h001A),  // R5 clear
    mk(OW,1,4'h0,16'h0000), mk(OR,1,4'h0,16'h001A),  // R5 R4 zero no effect
    mk(OW,1,4'h1,16'h0010), mk(OR,1,4'h0,16'h001A),  // R6
    mk(OW,1,4'h0,16'h0010), mk(OR,1,4'h0,16'h0002),  // R5 R8
    mk(OP,1,4'h6,16'h0000), mk(OR,1,4'h0,16'h006A),  // R8
    mk(OW,1,4'h0,16'h0007), mk(OR,1,4'h0,16'h0004),  // R3 R7
    mk(OW,1,4'h0,16'h0001), mk(OR,1,4'h0,16'h0001),  // R4 init
    mk(OW,1,4'h0,16'h0004)
  };
  localparam string TAG [NV] = '{
    "R1","R1","R2","R9","R9","R9","R10","R10","R10","R2","R4","R4","R4",
    "R9","R9","R9","R5","R5","R5","R8","R8","R5","R5","R5","R5","R6","R6",
    "R5","R5","R8","R8","R3","R3","R4","R4","R3"};

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_port = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [3:0] ev_set = '0;
  logic stop_o, start_o, init_o;
  logic [NCFG*DW-1:0] cfg_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctl_regfile #(.DW(DW), .IW(IW), .NCFG(NCFG)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_set(ev_set),
    .stop_o(stop_o), .start_o(start_o), .init_o(init_o), .cfg_o(cfg_o));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic p, logic [DW-1:0] d);
    @(negedge clk); bus_wr = 1; bus_port = p; bus_wdata = d; ev_set = 0;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic p, string req, logic [DW-1:0] exp);
    @(negedge clk); bus_wr = 0; bus_port = p; ev_set = 0;
    #1 chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", {13'd0, stop_o, start_o, init_o}, 16'h0004);
    chk("R1", cfg_o[15:0], 16'h0000);
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      bus_port = VEC[k][20];
      if (VEC[k][22:21] == OR) begin
        bus_wr = 0; ev_set = 0;
        #1 chk(TAG[k], bus_rdata, VEC[k][15:0]);
      end else begin
        bus_wr = (VEC[k][22:21] == OW);
        bus_wdata = VEC[k][15:0];
        ev_set = VEC[k][19:16];
      end
    end
    @(negedge clk); bus_wr = 0; ev_set = 0;
    chk("R3", {13'd0, stop_o, start_o, init_o}, 16'h0004);
    wr(1, 16'h0003);
    chk("R4", {13'd0, stop_o, start_o, init_o}, 16'h0003);
    wr(0, 16'h0003); wr(1, 16'h5555);
    rd(1, "R9", 16'h0000);
    chk("R9", cfg_o[47:32], 16'h0000);
    wr(0, 16'h003F); wr(1, 16'hAAAA);
    rd(1, "R10", 16'h0000);
    chk("R10", cfg_o[15:0], 16'h1234);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(0, "R1", 16'h0000);
    rd(1, "R1", 16'h0004);
    chk("R1", cfg_o[15:0], 16'h0000);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule